// File: doc/BRIEF.md
# System Control Port Register File

This block is a byte-wide register file that answers a small legacy range of system-control I/O ports. A host bus reaches it through a synchronous interface. Each access presents a 12-bit port number with a write strobe and write data, or with a read strobe. Read data comes back from a register one clock after the read strobe.

Writes to a few ports drive machine-level controls:
- a soft reset request;
- little-endian mode;
- a disk-activity light;
- a 4-bit system-control field;
- the I/O map type.

Two ports produce no stored state. A write to either of them emits a one-cycle pulse that toggles a lock in an external non-volatile memory. Several other ports return fixed identification bytes when read. Any write to a port the block does not implement raises a one-cycle error flag, so an integrator can see when the decode is incomplete.

The block also contains a combinational address translator. It turns an offset inside the 8 MB CPU I/O window, which is based at 0x80000000, into a 16-bit bus port address. The stored map-type bit selects between two forms. In contiguous form the translator masks the offset. In scattered form it keeps offset bits [4:0] and moves offset bits [22:12] down by seven places.

Top module: `sysctl_ports`

## Requirements
- R1: A write to port 0x092 loads `resetReq` from data bit 0 and `littleEndian` from data bit 1, both visible on the cycle after the write. A read of 0x092 returns 0x00.
- R2: A write to port 0x808 loads `lightOn` from data bit 0. Data bits 7..1 have no effect.
- R3: A write to port 0x810 makes `lockToggle1` high for exactly the next cycle. A write to port 0x812 does the same on `lockToggle2`. The write data does not matter.
- R4: A write to port 0x81C stores data bits 3..0 on `sysCtl`. A read of 0x81C returns that value in bits 3..0, with zero in bits 7..4.
- R5: A write to port 0x850 stores data bit 0 on `mapNonContig`. A read of 0x850 returns that bit in bit 0, with zero elsewhere.
- R6: Reads of the identification ports return fixed bytes: 0x800 gives 0xEF, 0x802 gives 0xAD, 0x803 gives 0xE0, 0x80C gives 0x3C, 0x810 gives 0x39, 0x818 gives 0x00, and 0x823 gives 0x03.
- R7: A read of 0x814 returns 0xFF, and so does a read of any port not named in R1 to R6. Writes to 0x800, 0x802, 0x803, 0x814 and to unimplemented ports change no output.
- R8: `badWrite` is high for the one cycle after a write to any port other than 0x092, 0x800, 0x802, 0x803, 0x808, 0x810, 0x812, 0x814, 0x81C or 0x850. Otherwise it is low.
- R9: When `mapNonContig` is 0, `ioAddr` equals `winOffset[15:0]`.
- R10: When `mapNonContig` is 1, `ioAddr[4:0]` equals `winOffset[4:0]` and `ioAddr[15:5]` equals `winOffset[22:12]`.
- R11: While the synchronous active-high `rst` is sampled high, every stored control, both pulses, `badWrite` and `busRdData` clear to 0 on the next edge.
- R12: `busRdData` takes the value of the port read on the edge after `busRd` is sampled high. When read and write hit the same port in the same cycle, the value returned is the one from before the write. With `busRd` low, `busRdData` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 12 | Port number of the access |
| busWr | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRd | input | 1 | Read strobe |
| busRdData | output | 8 | Registered read data |
| resetReq | output | 1 | Soft reset request |
| littleEndian | output | 1 | Little-endian mode select |
| lightOn | output | 1 | Disk-activity light |
| sysCtl | output | 4 | System-control field |
| mapNonContig | output | 1 | I/O map type, 1 = scattered |
| lockToggle1 | output | 1 | One-cycle lock toggle pulse, first lock |
| lockToggle2 | output | 1 | One-cycle lock toggle pulse, second lock |
| badWrite | output | 1 | One-cycle pulse after a write to an unimplemented port |
| winOffset | input | 23 | Offset inside the CPU I/O window |
| ioAddr | output | 16 | Translated bus port address |

## Verification
The properties assume that `busAddr`, `busWr`, `busWrData` and `busRd` are steady around each rising edge. The pulse and hold properties compare an output with the strobes of the previous cycle. They are therefore guarded so that they do not look back across the reset cycle. The stimulus changes every input one time unit after a rising edge and keeps `busWr` and `busRd` low while reset is applied. The random phase draws ports from the implemented set together with arbitrary 12-bit values, which places unimplemented ports and simultaneous read-write pairs under the properties.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int PORT_W  = 12;
  localparam int DATA_W  = 8;
  localparam int CTL_W   = 4;
  localparam int WIN_W   = 23;
  localparam int IO_W    = 16;

  localparam logic [PORT_W-1:0] PortSpecial  = 12'h092;
  localparam logic [PORT_W-1:0] PortCpuCfg   = 12'h800;
  localparam logic [PORT_W-1:0] PortFeat     = 12'h802;
  localparam logic [PORT_W-1:0] PortStat     = 12'h803;
  localparam logic [PORT_W-1:0] PortLight    = 12'h808;
  localparam logic [PORT_W-1:0] PortEquip    = 12'h80C;
  localparam logic [PORT_W-1:0] PortLockA    = 12'h810;
  localparam logic [PORT_W-1:0] PortLockB    = 12'h812;
  localparam logic [PORT_W-1:0] PortCacheInv = 12'h814;
  localparam logic [PORT_W-1:0] PortKeySw    = 12'h818;
  localparam logic [PORT_W-1:0] PortSysCtl   = 12'h81C;
  localparam logic [PORT_W-1:0] PortCacheSt  = 12'h823;
  localparam logic [PORT_W-1:0] PortMapType  = 12'h850;

  typedef enum logic [1:0] {
    SRC_CONST  = 2'd0,
    SRC_SYSCTL = 2'd1,
    SRC_MAP    = 2'd2
  } rdsrc_t;

  typedef struct packed {
    logic              setSpecial;
    logic              setLight;
    logic              setSysCtl;
    logic              setMap;
    logic              pulseLockA;
    logic              pulseLockB;
    logic              badWr;
    logic              rdEn;
    rdsrc_t            rdSrc;
    logic [DATA_W-1:0] rdConst;
  } strobe_t;
endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
(
  input  logic [PORT_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output strobe_t           strb
);
  logic wrKnown;

  always_comb begin
    strb = '0;
    strb.rdEn    = busRd;
    strb.rdSrc   = SRC_CONST;
    strb.rdConst = 8'hFF;
    wrKnown      = 1'b1;

    unique case (busAddr)
      PortSpecial:  strb.setSpecial = busWr;
      PortLight:    strb.setLight   = busWr;
      PortLockA:    strb.pulseLockA = busWr;
      PortLockB:    strb.pulseLockB = busWr;
      PortSysCtl:   strb.setSysCtl  = busWr;
      PortMapType:  strb.setMap     = busWr;
      PortCpuCfg, PortFeat, PortStat, PortCacheInv: ;
      default:      wrKnown = 1'b0;
    endcase

    unique case (busAddr)
      PortSpecial:  strb.rdConst = 8'h00;
      PortCpuCfg:   strb.rdConst = 8'hEF;
      PortFeat:     strb.rdConst = 8'hAD;
      PortStat:     strb.rdConst = 8'hE0;
      PortEquip:    strb.rdConst = 8'h3C;
      PortLockA:    strb.rdConst = 8'h39;
      PortKeySw:    strb.rdConst = 8'h00;
      PortCacheSt:  strb.rdConst = 8'h03;
      PortSysCtl:   strb.rdSrc   = SRC_SYSCTL;
      PortMapType:  strb.rdSrc   = SRC_MAP;
      default:      strb.rdConst = 8'hFF;
    endcase

    strb.badWr = busWr & ~wrKnown;
  end
endmodule

// File: rtl/sysctl_xlate.sv
module sysctl_xlate #(
  parameter int WIN_W    = 23,
  parameter int IO_W     = 16,
  parameter int LOW_KEEP = 5,
  parameter int HI_BASE  = 12,
  parameter int SHIFT    = 7
) (
  input  logic [WIN_W-1:0] winOffset,
  input  logic             nonContig,
  output logic [IO_W-1:0]  ioAddr
);
  localparam int HI_DST = HI_BASE - SHIFT;
  localparam int HI_CNT = WIN_W - HI_BASE;

  logic [IO_W-1:0] flatAddr;
  logic [IO_W-1:0] scatAddr;

  assign flatAddr = winOffset[IO_W-1:0];

  genvar g;
  generate
    for (g = 0; g < IO_W; g++) begin : g_bit
      if (g < LOW_KEEP) begin : g_low
        assign scatAddr[g] = winOffset[g];
      end else if (g >= HI_DST && g < HI_DST + HI_CNT) begin : g_high
        assign scatAddr[g] = winOffset[g + SHIFT];
      end else begin : g_zero
        assign scatAddr[g] = 1'b0;
      end
    end
  endgenerate

  assign ioAddr = nonContig ? scatAddr : flatAddr;
endmodule

// File: rtl/sysctl_dpath.sv
module sysctl_dpath
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              resetReq,
  output logic              littleEndian,
  output logic              lightOn,
  output logic [CTL_W-1:0]  sysCtl,
  output logic              mapNonContig,
  output logic              lockToggle1,
  output logic              lockToggle2,
  output logic              badWrite
);
  logic [DATA_W-1:0] rdNext;

  always_comb begin
    unique case (strb.rdSrc)
      SRC_SYSCTL: rdNext = {{(DATA_W-CTL_W){1'b0}}, sysCtl};
      SRC_MAP:    rdNext = {{(DATA_W-1){1'b0}}, mapNonContig};
      default:    rdNext = strb.rdConst;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resetReq     <= 1'b0;
      littleEndian <= 1'b0;
      lightOn      <= 1'b0;
      sysCtl       <= '0;
      mapNonContig <= 1'b0;
      lockToggle1  <= 1'b0;
      lockToggle2  <= 1'b0;
      badWrite     <= 1'b0;
      busRdData    <= '0;
    end else begin
      if (strb.setSpecial) begin
        resetReq     <= busWrData[0];
        littleEndian <= busWrData[1];
      end
      if (strb.setLight)  lightOn      <= busWrData[0];
      if (strb.setSysCtl) sysCtl       <= busWrData[CTL_W-1:0];
      if (strb.setMap)    mapNonContig <= busWrData[0];
      lockToggle1 <= strb.pulseLockA;
      lockToggle2 <= strb.pulseLockB;
      badWrite    <= strb.badWr;
      if (strb.rdEn) busRdData <= rdNext;
    end
  end
endmodule

// File: rtl/sysctl_ports.sv
module sysctl_ports
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRd,
  output logic [DATA_W-1:0] busRdData,
  output logic              resetReq,
  output logic              littleEndian,
  output logic              lightOn,
  output logic [CTL_W-1:0]  sysCtl,
  output logic              mapNonContig,
  output logic              lockToggle1,
  output logic              lockToggle2,
  output logic              badWrite,
  input  logic [WIN_W-1:0]  winOffset,
  output logic [IO_W-1:0]   ioAddr
);
  strobe_t strb;

  sysctl_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .strb    (strb)
  );

  sysctl_dpath u_dpath (
    .clk          (clk),
    .rst          (rst),
    .strb         (strb),
    .busWrData    (busWrData),
    .busRdData    (busRdData),
    .resetReq     (resetReq),
    .littleEndian (littleEndian),
    .lightOn      (lightOn),
    .sysCtl       (sysCtl),
    .mapNonContig (mapNonContig),
    .lockToggle1  (lockToggle1),
    .lockToggle2  (lockToggle2),
    .badWrite     (badWrite)
  );

  sysctl_xlate #(.WIN_W(WIN_W), .IO_W(IO_W)) u_xlate (
    .winOffset (winOffset),
    .nonContig (mapNonContig),
    .ioAddr    (ioAddr)
  );
endmodule

// File: rtl/sysctl_checks.sv
module sysctl_checks
  import sysctl_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [PORT_W-1:0] busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic [DATA_W-1:0] busRdData,
  input logic              resetReq,
  input logic              mapNonContig,
  input logic [CTL_W-1:0]  sysCtl,
  input logic              lockToggle1,
  input logic              lockToggle2,
  input logic              badWrite,
  input logic [WIN_W-1:0]  winOffset,
  input logic [IO_W-1:0]   ioAddr
);
  p_lock_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (lockToggle1 == $past(busWr && busAddr == PortLockA)
                     && lockToggle2 == $past(busWr && busAddr == PortLockB)));

  p_sysctl_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(busWr && busAddr == PortSysCtl)) |-> $stable(sysCtl));

  p_cpu_cfg_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(busRd && busAddr == PortCpuCfg)) |-> busRdData == 8'hEF);

  p_bad_after_write_r8: assert property (@(posedge clk) disable iff (rst)
    badWrite |-> $past(busWr));

  p_flat_map_r9: assert property (@(posedge clk) disable iff (rst)
    !mapNonContig |-> ioAddr == winOffset[IO_W-1:0]);

  p_scatter_map_r10: assert property (@(posedge clk) disable iff (rst)
    mapNonContig |-> (ioAddr[4:0] == winOffset[4:0] && ioAddr[15:5] == winOffset[22:12]));

  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (!resetReq && !mapNonContig && sysCtl == '0 && !badWrite));
endmodule

bind sysctl_ports sysctl_checks u_checks (
  .clk          (clk),
  .rst          (rst),
  .busAddr      (busAddr),
  .busWr        (busWr),
  .busRd        (busRd),
  .busRdData    (busRdData),
  .resetReq     (resetReq),
  .mapNonContig (mapNonContig),
  .sysCtl       (sysCtl),
  .lockToggle1  (lockToggle1),
  .lockToggle2  (lockToggle2),
  .badWrite     (badWrite),
  .winOffset    (winOffset),
  .ioAddr       (ioAddr)
);

// File: tb/test_sysctl_ports.sv
module test_sysctl_ports;
  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] busAddr = '0;
  logic        busWr = 1'b0;
  logic [7:0]  busWrData = '0;
  logic        busRd = 1'b0;
  logic [22:0] winOffset = '0;
  logic [7:0]  busRdData;
  logic        resetReq, littleEndian, lightOn, mapNonContig;
  logic [3:0]  sysCtl;
  logic        lockToggle1, lockToggle2, badWrite;
  logic [15:0] ioAddr;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  // reference state
  bit       mReset, mEndian, mLight, mMap, mLock1, mLock2, mBad;
  bit [3:0] mCtl;
  bit [7:0] mRd;
  string    rdTag = "R11";

  always #(ClkPeriod/2) clk = ~clk;

  sysctl_ports i_sysctl_ports (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .busRd(busRd), .busRdData(busRdData),
    .resetReq(resetReq), .littleEndian(littleEndian), .lightOn(lightOn),
    .sysCtl(sysCtl), .mapNonContig(mapNonContig), .lockToggle1(lockToggle1),
    .lockToggle2(lockToggle2), .badWrite(badWrite), .winOffset(winOffset),
    .ioAddr(ioAddr)
  );

  function automatic int readValue(int a);
    case (a)
      'h092: return 'h00;
      'h800: return 'hEF;
      'h802: return 'hAD;
      'h803: return 'hE0;
      'h80C: return 'h3C;
      'h810: return 'h39;
      'h818: return 'h00;
      'h823: return 'h03;
      'h81C: return mCtl;
      'h850: return mMap;
      default: return 'hFF;
    endcase
  endfunction

  function automatic string readTag(int a);
    case (a)
      'h800, 'h802, 'h803, 'h80C, 'h810, 'h818, 'h823: return "R6";
      'h092: return "R1";
      'h81C: return "R4";
      'h850: return "R5";
      default: return "R7";
    endcase
  endfunction

  function automatic bit knownWrite(int a);
    case (a)
      'h092, 'h800, 'h802, 'h803, 'h808, 'h810, 'h812, 'h814, 'h81C, 'h850: return 1;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      {mReset, mEndian, mLight, mMap, mLock1, mLock2, mBad} = '0;
      mCtl = 0; mRd = 0; rdTag = "R11";
    end else begin
      if (busRd) begin
        mRd = 8'(readValue(int'(busAddr)));
        rdTag = readTag(int'(busAddr));
      end
      mLock1 = busWr && busAddr == 12'h810;
      mLock2 = busWr && busAddr == 12'h812;
      mBad   = busWr && !knownWrite(int'(busAddr));
      if (busWr) begin
        case (busAddr)
          12'h092: begin mReset = busWrData[0]; mEndian = busWrData[1]; end
          12'h808: mLight = busWrData[0];
          12'h81C: mCtl = busWrData[3:0];
          12'h850: mMap = busWrData[0];
          default: ;
        endcase
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cycles, act, exp);
    end
  endtask

  function automatic int expIo(bit scat, bit [22:0] off);
    if (!scat) return off % 65536;
    return (off % 32) + ((off / 4096) % 2048) * 32;
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      check("R1 resetReq", resetReq, mReset);
      check("R1 littleEndian", littleEndian, mEndian);
      check("R2 lightOn", lightOn, mLight);
      check("R3 lockToggle1", lockToggle1, mLock1);
      check("R3 lockToggle2", lockToggle2, mLock2);
      check("R4 sysCtl", sysCtl, mCtl);
      check("R5 mapNonContig", mapNonContig, mMap);
      check("R8 badWrite", badWrite, mBad);
      check({"R12 busRdData ", rdTag}, busRdData, mRd);
      check(mMap ? "R10 ioAddr" : "R9 ioAddr", ioAddr, expIo(mMap, winOffset));
      if (cycles > 20000) begin
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
        finishRun();
      end
    end
  end

  task automatic finishRun();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic stepIn(bit wr, bit rd, int a, int d, int off);
    @(posedge clk); #1;
    busWr = wr; busRd = rd; busAddr = 12'(a); busWrData = 8'(d); winOffset = 23'(off);
  endtask

  task automatic wr(int a, int d); stepIn(1, 0, a, d, int'(winOffset)); endtask
  task automatic rd(int a);        stepIn(0, 1, a, 0, int'(winOffset)); endtask
  task automatic idle();           stepIn(0, 0, int'(busAddr), 0, int'(winOffset)); endtask

  initial begin
    int ports[14] = '{'h092, 'h800, 'h802, 'h803, 'h808, 'h80C, 'h810,
                      'h812, 'h814, 'h818, 'h81C, 'h823, 'h850, 'h851};
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R11 reset state
    @(negedge clk);
    check("R11 reset sysCtl", sysCtl, 0);
    check("R11 reset rdData", busRdData, 0);
    // R1 special port
    wr('h092, 'h03); idle(); wr('h092, 'h02); rd('h092); idle();
    // R2 light, upper bits ignored
    wr('h808, 'hFE); wr('h808, 'h01); idle();
    // R3 lock pulses, data ignored, back-to-back
    wr('h810, 'h00); idle(); wr('h812, 'hAA); wr('h812, 'h55); idle();
    // R4 / R5 stores and readback, same-cycle read/write (R12)
    wr('h81C, 'hF9); rd('h81C); stepIn(1, 1, 'h81C, 'h06, 0); rd('h81C); idle();
    // R7 writes to read-only and unlisted ports, R8 error flag
    wr('h800, 'hFF); wr('h814, 'hFF); wr('h80C, 'hFF); wr('h123, 'hFF); idle();
    // R6 constant reads and R7 0xFF reads
    foreach (ports[i]) rd(ports[i]);
    idle(); idle();
    // R9 / R10 translation sweep
    for (int m = 0; m < 2; m++) begin
      wr('h850, m);
      for (int k = 0; k < 23; k++) stepIn(0, 0, 0, 0, 1 << k);
      stepIn(0, 0, 0, 0, 'h7FFFFF);
      stepIn(0, 0, 0, 0, 'h2A5A5A);
    end
    rd('h850);
    // random phase
    for (int n = 0; n < 600; n++) begin
      int a = ($urandom % 3 == 0) ? int'($urandom % 4096) : ports[$urandom % 14];
      stepIn(bit'($urandom % 2), bit'($urandom % 2), a, int'($urandom % 256),
             int'($urandom % (1 << 23)));
    end
    // mid-run reset: R11
    wr('h092, 'h03); wr('h850, 1);
    @(posedge clk); #1 rst = 1; busWr = 0; busRd = 0;
    @(posedge clk); #1 rst = 0;
    @(negedge clk);
    check("R11 resetReq cleared", resetReq, 0);
    check("R11 map cleared", mapNonContig, 0);
    idle(); idle();
    finishRun();
  end
endmodule